// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port with RS485 Driver Enable

This block is a full-duplex asynchronous serial transmitter and receiver for a bridge-style peripheral. Bytes to send arrive on a valid/ready interface and leave on `tx_line` as start, data, optional parity and stop bits. An RS485 driver-enable output, `tx_en`, is raised automatically with no software involvement. It goes high one bit time before the start bit and stays high until the last stop bit has finished. Arriving frames on `rx_line` are oversampled, checked for framing and parity, and held in a single holding register with their error flags until they are consumed.

The frame format is selected at run time. The data length is 7 or 8 bits and the frame carries 1 or 2 stop bits. The parity field is one of none, odd, even, mark or space. `baud_div` sets the rate. The transmitter waits while the far end withdraws `cts`. `rts` tells the far end when the receive holding register is occupied.

The transmitter has six states:
- `TX_IDLE`: line high, enable low.
- `TX_LEAD`: enable high, line high for one bit.
- `TX_START`
- `TX_DATA`
- `TX_PARITY`
- `TX_STOP`

Its transitions:
- IDLE→LEAD on an accepted byte.
- LEAD→START after one bit time.
- START→DATA after one bit time.
- DATA→PARITY or DATA→STOP after the last data bit.
- PARITY→STOP after one bit time.
- STOP→IDLE after the last stop bit.

The receiver has five states: `RX_IDLE`, `RX_START`, `RX_DATA`, `RX_PARITY` and `RX_STOP`. Its transitions:
- IDLE→START when a low is seen on a 16x tick.
- START→IDLE if the line is high again at mid-bit.
- START→DATA if the line is still low at mid-bit.
- DATA→PARITY or DATA→STOP after the last data bit.
- PARITY→STOP after one bit time.
- STOP→IDLE after the stop sample.

Top module: `uart485_core`

## Requirements
- R1: One bit time on both lines is 16 oversampling ticks, and one tick occurs every `baud_div` clock cycles (a divisor of 0 behaves as 1).
- R2: A transmitted frame is one low start bit, then the data bits least significant first, then the optional parity bit, then high stop bits. In 7-bit mode (`cfg_seven`=1) only `tx_data[6:0]` are sent and bit 7 is ignored.
- R3: `cfg_parity` encodes 0 = none (no parity bit), 1 = odd, 2 = even, 3 = mark (bit is 1) and 4 = space (bit is 0). Odd and even parity count only the data bits actually sent.
- R4: With `cfg_two_stop`=1 the frame ends with two stop bit times, otherwise one.
- R5: `tx_en` rises one bit time (within one tick) before the start bit. It stays high through the last stop bit and is low within one bit time after the frame ends. Whenever `tx_line` is low, `tx_en` is high.
- R6: While `cts` is low no frame starts, `tx_ready` is low and `tx_line` stays high. A frame starts once `cts` returns high.
- R7: The receiver confirms a start bit at mid-bit. A low pulse shorter than half a bit is ignored and produces no byte.
- R8: A received byte is presented on `rx_data` with `rx_valid`, and held unchanged until `rx_ready` is seen. In 7-bit mode `rx_data[7]` reads 0. A frame that completes while the holding register is full is dropped.
- R9: `rx_frame_err` is 1 for a byte whose first stop bit sampled low. The byte is still delivered.
- R10: `rx_parity_err` is 1 for a byte whose parity bit differs from the configured mode. The byte is still delivered.
- R11: `rts` is low exactly while the receive holding register holds an unconsumed byte.
- R12: After reset `tx_line` is high, `tx_en` is low, `rx_valid` is low and `rts` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Clock cycles per 16x tick |
| cfg_seven | input | 1 | 1 = 7 data bits, 0 = 8 |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_parity | input | 3 | Parity mode code (see R3) |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter accepts a byte this cycle |
| tx_line | output | 1 | Serial output, idle high |
| tx_en | output | 1 | RS485 driver enable |
| cts | input | 1 | Far end clear to send, active high |
| rx_line | input | 1 | Serial input, idle high |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Holding register occupied |
| rx_ready | input | 1 | Consumer takes the held byte |
| rx_frame_err | output | 1 | Framing error for held byte |
| rx_parity_err | output | 1 | Parity error for held byte |
| rts | output | 1 | Ready to receive, active high |

## Verification
The bench measures the gap from `tx_en` rising to the start edge. A design that raised the enable together with the start bit, or dropped it before the second stop bit ended, fails that window. It runs 7-bit frames with bit 7 set in both directions, so a design that leaks the top bit onto the wire or into `rx_data` is caught. It drives every parity code on both sides, and drives a bad parity bit and a low stop bit, to catch a swapped odd/even sense or a byte withheld on error. A half-bit glitch, a second frame arriving while the holding register is full, and a withdrawn `cts` expose a receiver that trusts the edge alone, a holding register that is overwritten, and a transmitter that ignores flow control.

// File: rtl/uart485_pkg.sv
package uart485_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } parity_e;

    // Value carried by the parity bit for a given mode and data word.
    function automatic logic par_of(parity_e m, logic [7:0] d);
        case (m)
            PAR_ODD:   return ~(^d);
            PAR_EVEN:  return ^d;
            PAR_MARK:  return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

    // True when the mode puts a parity bit in the frame.
    function automatic logic par_on(parity_e m);
        return (m == PAR_ODD) || (m == PAR_EVEN) || (m == PAR_MARK) || (m == PAR_SPACE);
    endfunction

endpackage

// File: rtl/uart485_tick.sv
module uart485_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // A divisor of zero is treated as one: a tick on every cycle.
    assign limit = (div == '0) ? '0 : div - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= limit) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

endmodule

// File: rtl/uart485_tx.sv
module uart485_tx
    import uart485_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       seven,
    input  logic       two_stop,
    input  parity_e    pmode,
    input  logic [7:0] data,
    input  logic       valid,
    input  logic       cts,
    output logic       ready,
    output logic       line,
    output logic       drv_en
);
    localparam int CW = $clog2(OVS);

    typedef enum logic [2:0] {
        TX_IDLE, TX_LEAD, TX_START, TX_DATA, TX_PARITY, TX_STOP
    } tx_state_e;

    tx_state_e       state_q, state_d;
    logic [CW-1:0]   tcnt_q;
    logic [2:0]      bit_q;
    logic            stop_q;
    logic [7:0]      sh_q;
    logic            seven_q, two_q, par_q, paren_q;
    logic [7:0]      data_m;
    logic            bit_done, accept;
    logic [2:0]      last_bit;

    assign data_m   = seven ? {1'b0, data[6:0]} : data;
    assign bit_done = tick && (tcnt_q == CW'(OVS - 1));
    assign accept   = (state_q == TX_IDLE) && valid && cts;
    assign last_bit = seven_q ? 3'd6 : 3'd7;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (accept)   state_d = TX_LEAD;
            TX_LEAD:   if (bit_done) state_d = TX_START;
            TX_START:  if (bit_done) state_d = TX_DATA;
            TX_DATA:   if (bit_done && bit_q == last_bit)
                           state_d = paren_q ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_done) state_d = TX_STOP;
            TX_STOP:   if (bit_done && stop_q == two_q) state_d = TX_IDLE;
            default:   state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q  <= '0;
            bit_q   <= '0;
            stop_q  <= 1'b0;
            sh_q    <= '0;
            seven_q <= 1'b0;
            two_q   <= 1'b0;
            par_q   <= 1'b0;
            paren_q <= 1'b0;
        end else begin
            if (accept) begin
                sh_q    <= data_m;
                seven_q <= seven;
                two_q   <= two_stop;
                paren_q <= par_on(pmode);
                par_q   <= par_of(pmode, data_m);
            end
            if (state_q == TX_IDLE)
                tcnt_q <= '0;
            else if (tick)
                tcnt_q <= (tcnt_q == CW'(OVS - 1)) ? '0 : tcnt_q + 1'b1;
            if (state_q != TX_DATA)  bit_q <= '0;
            else if (bit_done)       bit_q <= bit_q + 1'b1;
            if (state_q != TX_STOP)  stop_q <= 1'b0;
            else if (bit_done)       stop_q <= 1'b1;
        end
    end

    always_comb begin
        ready  = (state_q == TX_IDLE) && cts;
        drv_en = (state_q != TX_IDLE);
        unique case (state_q)
            TX_START:  line = 1'b0;
            TX_DATA:   line = sh_q[bit_q];
            TX_PARITY: line = par_q;
            default:   line = 1'b1;
        endcase
    end

    // R5: a low line only ever appears inside the driver-enable window
    a_r5_low_inside_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !line |-> drv_en);
    // R5: the enable falls only after a high stop bit
    a_r5_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> line && $past(line));
    // R6: withdrawn cts keeps the transmitter idle
    a_r6_hold_without_cts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE && !cts) |=> state_q == TX_IDLE);
    // R2: an accepting transmitter has a quiet, released line
    a_r2_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> line && !drv_en);

endmodule

// File: rtl/uart485_rx.sv
module uart485_rx
    import uart485_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line_in,
    input  logic       seven,
    input  parity_e    pmode,
    input  logic       take,
    output logic [7:0] data_o,
    output logic       valid_o,
    output logic       ferr_o,
    output logic       perr_o
);
    localparam int CW = $clog2(OVS);

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP
    } rx_state_e;

    rx_state_e       state_q, state_d;
    logic [1:0]      sync_q;
    logic            rxs;
    logic [CW-1:0]   tcnt_q;
    logic [2:0]      bit_q;
    logic [7:0]      dat_q;
    logic [7:0]      dat_m;
    logic            prx_q;
    logic            mid_hit, full_hit, deliver;
    logic [2:0]      last_bit;

    assign rxs      = sync_q[1];
    assign mid_hit  = tick && (tcnt_q == CW'(OVS / 2 - 1));
    assign full_hit = tick && (tcnt_q == CW'(OVS - 1));
    assign last_bit = seven ? 3'd6 : 3'd7;
    assign dat_m    = seven ? {1'b0, dat_q[6:0]} : dat_q;
    assign deliver  = (state_q == RX_STOP) && full_hit && !valid_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (tick && !rxs) state_d = RX_START;
            RX_START:  if (mid_hit)      state_d = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:   if (full_hit && bit_q == last_bit)
                           state_d = par_on(pmode) ? RX_PARITY : RX_STOP;
            RX_PARITY: if (full_hit)     state_d = RX_STOP;
            RX_STOP:   if (full_hit)     state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            tcnt_q <= '0;
            bit_q  <= '0;
            dat_q  <= '0;
            prx_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], line_in};
            if (state_q == RX_IDLE || (state_q == RX_START && mid_hit))
                tcnt_q <= '0;
            else if (tick)
                tcnt_q <= (tcnt_q == CW'(OVS - 1)) ? '0 : tcnt_q + 1'b1;
            if (state_q != RX_DATA) bit_q <= '0;
            else if (full_hit) begin
                dat_q[bit_q] <= rxs;
                bit_q        <= bit_q + 1'b1;
            end
            if (state_q == RX_PARITY && full_hit) prx_q <= rxs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
            perr_o  <= 1'b0;
        end else if (deliver) begin
            data_o  <= dat_m;
            valid_o <= 1'b1;
            ferr_o  <= !rxs;
            perr_o  <= par_on(pmode) && (prx_q != par_of(pmode, dat_m));
        end else if (take) begin
            valid_o <= 1'b0;
        end
    end

    // R7: data sampling begins only after a low mid-bit start sample
    a_r7_start_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_DATA && $past(state_q) == RX_START) |-> !$past(rxs));
    // R8: a held byte stays put until it is taken
    a_r8_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !take) |=> valid_o && $stable(data_o));
    // R8: 7-bit bytes arrive with a clear top bit
    a_r8_seven_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver && seven) |=> !data_o[7]);
    // R9: the framing flag mirrors the stop sample
    a_r9_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |=> ferr_o == !$past(rxs));

endmodule

// File: rtl/uart485_core.sv
module uart485_core
    import uart485_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             cfg_seven,
    input  logic             cfg_two_stop,
    input  logic [2:0]       cfg_parity,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             tx_line,
    output logic             tx_en,
    input  logic             cts,
    input  logic             rx_line,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic             rx_frame_err,
    output logic             rx_parity_err,
    output logic             rts
);
    logic    tick;
    parity_e pmode;

    assign pmode = parity_e'(cfg_parity);

    uart485_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (baud_div),
        .tick (tick)
    );

    uart485_tx #(.OVS(OVS)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .seven   (cfg_seven),
        .two_stop(cfg_two_stop),
        .pmode   (pmode),
        .data    (tx_data),
        .valid   (tx_valid),
        .cts     (cts),
        .ready   (tx_ready),
        .line    (tx_line),
        .drv_en  (tx_en)
    );

    uart485_rx #(.OVS(OVS)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .line_in(rx_line),
        .seven  (cfg_seven),
        .pmode  (pmode),
        .take   (rx_ready),
        .data_o (rx_data),
        .valid_o(rx_valid),
        .ferr_o (rx_frame_err),
        .perr_o (rx_parity_err)
    );

    assign rts = !rx_valid;

endmodule

// File: tb/uart485_core_test.sv
module uart485_core_test;
    localparam int BIT = 32;   // baud_div 2 x 16 ticks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [15:0] baud_div = 16'd2;
    logic       cfg_seven = 1'b0, cfg_two_stop = 1'b0;
    logic [2:0] cfg_parity = 3'd0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0, cts = 1'b1, rx_line = 1'b1, rx_ready = 1'b0;
    logic       tx_ready, tx_line, tx_en, rx_valid, rx_frame_err, rx_parity_err, rts;
    logic [7:0] rx_data;
    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    uart485_core uut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .cfg_seven(cfg_seven),
        .cfg_two_stop(cfg_two_stop), .cfg_parity(cfg_parity), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line), .tx_en(tx_en),
        .cts(cts), .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_frame_err(rx_frame_err),
        .rx_parity_err(rx_parity_err), .rts(rts)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_par(input int pm, input logic [7:0] d);
        case (pm)
            1: return ~(^d);
            2: return ^d;
            3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_cfg(input bit seven, input bit two, input int pm);
        @(negedge clk);
        cfg_seven = seven; cfg_two_stop = two; cfg_parity = 3'(pm);
    endtask

    // R12: reset values
    task automatic t_reset();
        wait_clk(2);
        chk(tx_line == 1'b1, "R12 tx_line", tx_line, 1);
        chk(tx_en == 1'b0, "R12 tx_en", tx_en, 0);
        chk(rx_valid == 1'b0, "R12 rx_valid", rx_valid, 0);
        chk(rts == 1'b1, "R12 rts", rts, 1);
    endtask

    // Send one byte and check every bit on the wire (R1..R6)
    task automatic t_tx(input logic [7:0] d, input bit seven, input bit two,
                        input int pm, input int cts_hold);
        int lead = 0, guard = 0;
        bit ok = 1;
        int nb = seven ? 7 : 8;
        logic [7:0] dm = seven ? {1'b0, d[6:0]} : d;
        set_cfg(seven, two, pm);
        if (cts_hold > 0) cts = 1'b0;
        tx_data = d; tx_valid = 1'b1;
        if (cts_hold > 0) begin
            for (int i = 0; i < cts_hold; i++) begin
                @(negedge clk);
                if (tx_en || !tx_line || tx_ready) ok = 0;
            end
            chk(ok, "R6 frame held while cts low", ok, 1);
            cts = 1'b1;
        end
        while (!tx_en && guard < 100) begin @(negedge clk); guard++; end
        tx_valid = 1'b0;
        while (tx_line && lead < 200) begin @(negedge clk); lead++; end
        chk(lead >= 29 && lead <= 34, "R5 enable leads start by one bit", lead, 32);
        wait_clk(BIT / 2);
        chk(tx_line == 1'b0, "R2 start bit", tx_line, 0);
        for (int i = 0; i < nb; i++) begin
            wait_clk(BIT);
            chk(tx_line == dm[i], "R2 data bit", tx_line, dm[i]);
        end
        if (pm != 0) begin
            wait_clk(BIT);
            chk(tx_line == exp_par(pm, dm), "R3 parity bit", tx_line, exp_par(pm, dm));
        end
        for (int i = 0; i < (two ? 2 : 1); i++) begin
            wait_clk(BIT);
            chk(tx_line == 1'b1 && tx_en == 1'b1, "R4 stop bit under enable",
                {tx_line, tx_en}, 3);
        end
        wait_clk(BIT / 2 + 4);
        chk(tx_en == 1'b0 && tx_line == 1'b1, "R5 enable released after frame",
            {tx_line, tx_en}, 2);
    endtask

    // Drive one frame onto rx_line
    task automatic rx_send(input logic [7:0] d, input bit seven, input bit two,
                           input int pm, input bit bad_par, input bit bad_stop);
        int nb = seven ? 7 : 8;
        logic [7:0] dm = seven ? {1'b0, d[6:0]} : d;
        @(negedge clk);
        rx_line = 1'b0; wait_clk(BIT);
        for (int i = 0; i < nb; i++) begin rx_line = d[i]; wait_clk(BIT); end
        if (pm != 0) begin rx_line = exp_par(pm, dm) ^ bad_par; wait_clk(BIT); end
        rx_line = !bad_stop; wait_clk(BIT);
        rx_line = 1'b1;
        if (two) wait_clk(BIT);
        wait_clk(4);
    endtask

    task automatic take();
        rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0; @(negedge clk);
        chk(rx_valid == 1'b0 && rts == 1'b1, "R11 rts back after take", rts, 1);
    endtask

    task automatic t_rx(input logic [7:0] d, input bit seven, input bit two, input int pm,
                        input bit bad_par, input bit bad_stop, input logic [7:0] exp_d);
        set_cfg(seven, two, pm);
        rx_send(d, seven, two, pm, bad_par, bad_stop);
        chk(rx_valid == 1'b1, "R8 byte delivered", rx_valid, 1);
        chk(rx_data == exp_d, "R8 received data", rx_data, exp_d);
        chk(rts == 1'b0, "R11 rts low while full", rts, 0);
        chk(rx_frame_err == bad_stop, "R9 framing flag", rx_frame_err, bad_stop);
        chk(rx_parity_err == bad_par, "R10 parity flag", rx_parity_err, bad_par);
        take();
    endtask

    // R7: short low pulse is not a start bit
    task automatic t_glitch();
        set_cfg(0, 0, 0);
        rx_line = 1'b0; wait_clk(6); rx_line = 1'b1;
        wait_clk(3 * BIT);
        chk(rx_valid == 1'b0, "R7 glitch ignored", rx_valid, 0);
        t_rx(8'h96, 0, 0, 0, 0, 0, 8'h96);
    endtask

    // R8: a full holding register keeps the first byte
    task automatic t_overrun();
        set_cfg(0, 0, 0);
        rx_send(8'h11, 0, 0, 0, 0, 0);
        rx_send(8'hEE, 0, 0, 0, 0, 0);
        chk(rx_valid && rx_data == 8'h11, "R8 first byte held over second", rx_data, 8'h11);
        chk(rts == 1'b0, "R11 rts low while held", rts, 0);
        take();
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        t_reset();
        t_tx(8'hA5, 0, 0, 0, 0);        // R1 R2 8N1
        t_tx(8'hC3, 1, 1, 2, 0);        // R2 R3 R4 7E2, bit 7 ignored
        t_tx(8'h5A, 0, 0, 1, 0);        // R3 odd
        t_tx(8'h00, 0, 0, 3, 0);        // R3 mark
        t_tx(8'hFF, 1, 0, 4, 0);        // R3 space, 7 bits
        t_tx(8'h3E, 0, 1, 0, 150);      // R6 cts hold
        t_rx(8'h3C, 0, 0, 0, 0, 0, 8'h3C);
        t_rx(8'hFF, 1, 0, 2, 0, 0, 8'h7F);   // R8 seven-bit top clear
        t_rx(8'h81, 0, 0, 1, 1, 0, 8'h81);   // R10 odd parity wrong
        t_rx(8'h42, 0, 0, 0, 0, 1, 8'h42);   // R9 low stop bit
        t_rx(8'h24, 0, 1, 3, 0, 0, 8'h24);   // R3 mark on receive
        t_rx(8'h24, 1, 0, 4, 0, 0, 8'h24);   // R3 space on receive
        t_glitch();
        t_overrun();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_clk(100000);
        checks++; failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule